// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits next to a simple in-order core. It decides whether an exception is taken and in which cycle, and it applies the machine-state changes for exception entry and for return. Seven request strobes can raise an exception: system reset, machine check, instruction-fetch storage fault, data storage fault, system call, external request and timer. When one is accepted, the block does four things in a single clock:
- it stores a return address in save register 0 (`srr0`);
- it stores a filtered copy of the state word, plus cause bits, in save register 1 (`srr1`);
- it moves the core into real-addressed supervisor mode;
- it pulses `redirect` together with the vector fetch address.

A return strobe reverses the entry. It copies save register 1 back into the state word and redirects the core to the address held in save register 0. The core can also load the state word directly when it executes a state-move instruction.

A machine check that arrives while the machine-check enable bit is clear does not enter its vector. Instead the block freezes in a checkstop state, and only the synchronous reset `rst` releases it.

Bit numbers in this brief count the most significant bit as bit 0, so bit b of a word sits at index 31-b. The state bits used are:

| Bit | Meaning |
|---|---|
| 16 | external enable |
| 17 | problem (user) state |
| 19 | machine-check enable |
| 25 | vector prefix |
| 26 | instruction translate |
| 27 | data translate |
| 30 | recoverable |

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls: `msr` equals parameter MSR_INIT; `srr0`, `srr1` and `redirect_pc` are 0; `redirect` and `checkstop` are 0.
- R2: On entry, `redirect_pc` is the vector base plus a fixed offset, and `redirect` pulses for one cycle. The base is VEC_HI_BASE when state bit 25 is 1 and 0 otherwise. The offsets are: reset 0x100, machine check 0x200, data storage 0x300, instruction storage 0x400, external 0x500, timer 0x900, system call 0xC00.
- R3: When several requests arrive in one cycle, only one is taken. The order from highest priority down is: reset, machine check, instruction storage, data storage, system call, external, timer.
- R4: External and timer requests are ignored while state bit 16 is 0. Reset and machine-check requests are never masked.
- R5: On entry, `srr1` takes state bits 0, 5-9 and 16-31; all other bits are 0, except the cause bits of an instruction storage fault. For that fault, `isi_code[3]` goes to bit 1 (hashed miss), `[2]` to bit 3 (direct-store segment), `[1]` to bit 4 (protection) and `[0]` to bit 10 (segment-table miss).
- R6: On entry, `srr0` takes `next_pc` for reset, system call, external and timer. It takes `cur_pc` for instruction storage, data storage and machine check.
- R7: On entry, state bits 16, 17, 26 and 27 are cleared and bit 30 is set (machine check excepted, see R8). All other state bits are kept.
- R8: On a machine-check entry, state bit 30 takes the value of `mc_state_valid`.
- R9: A machine-check request taken while state bit 19 is 0 sets `checkstop` and produces no redirect. While `checkstop` is 1, every request, return and load is ignored until `rst`.
- R10: A return strobe that is not overridden by an exception copies `srr1` into `msr`, sets `redirect_pc` to `srr0` and pulses `redirect`.
- R11: A state load writes `msr_wdata` into `msr`, but only in a cycle with no exception, checkstop entry or return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_sys_reset | input | 1 | System reset exception request |
| req_mcheck | input | 1 | Machine check request |
| req_isi | input | 1 | Instruction-fetch storage fault request |
| req_dsi | input | 1 | Data storage fault request |
| req_syscall | input | 1 | System call request |
| req_ext | input | 1 | External interrupt request |
| req_timer | input | 1 | Timer interrupt request |
| mc_state_valid | input | 1 | Machine-check state is recoverable |
| isi_code | input | 4 | Instruction fault cause flags |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the next instruction |
| rfi | input | 1 | Return-from-interrupt strobe |
| msr_load | input | 1 | Load state word strobe |
| msr_wdata | input | 32 | State word to load |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target address |
| msr | output | 32 | Machine state word |
| srr0 | output | 32 | Save register 0 |
| srr1 | output | 32 | Save register 1 |
| checkstop | output | 1 | Machine is checkstopped |

## Verification
The bench builds the block with MSR_INIT = 0x00001040, so the vector prefix and the machine-check enable are already set when reset ends. This makes the R1 check non-trivial, and a machine check taken straight after reset still enters its vector. VEC_HI_BASE stays at 0xFFF00000. Together these put both vector bases within reach, and a pseudo-random phase then mixes requests, returns and loads. The checkstop path is exercised last, after an explicit load clears bit 19.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  localparam int NSRC = 7;

  // source indices, highest priority first
  localparam int S_RST = 0;
  localparam int S_MC  = 1;
  localparam int S_ISI = 2;
  localparam int S_DSI = 3;
  localparam int S_SC  = 4;
  localparam int S_EXT = 5;
  localparam int S_TMR = 6;

  // state bit indices (bit 0 is the MSB)
  localparam int B_EE = XLEN-1-16;
  localparam int B_PR = XLEN-1-17;
  localparam int B_ME = XLEN-1-19;
  localparam int B_IP = XLEN-1-25;
  localparam int B_IR = XLEN-1-26;
  localparam int B_DR = XLEN-1-27;
  localparam int B_RI = XLEN-1-30;

  // instruction fault cause positions in srr1
  localparam int C_HASH = XLEN-1-1;
  localparam int C_DSEG = XLEN-1-3;
  localparam int C_PROT = XLEN-1-4;
  localparam int C_STAB = XLEN-1-10;

  typedef enum logic [2:0] {
    EXC_NONE, EXC_RST, EXC_MC, EXC_ISI, EXC_DSI, EXC_SC, EXC_EXT, EXC_TMR
  } exc_kind_e;

  function automatic logic [XLEN-1:0] keep_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int b = 0; b < XLEN; b++)
      if (b == 0 || (b >= 5 && b <= 9) || b >= 16) m[XLEN-1-b] = 1'b1;
    return m;
  endfunction

  function automatic logic [11:0] vec_offset(exc_kind_e k);
    case (k)
      EXC_RST: return 12'h100;
      EXC_MC:  return 12'h200;
      EXC_DSI: return 12'h300;
      EXC_ISI: return 12'h400;
      EXC_EXT: return 12'h500;
      EXC_TMR: return 12'h900;
      EXC_SC:  return 12'hC00;
      default: return 12'h000;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req,
  input  logic            ee,
  input  logic            me,
  input  logic            halted,
  output exc_kind_e       kind,
  output logic            take,
  output logic            stop_go
);
  logic [NSRC-1:0] eff;
  logic [NSRC-1:0] grant;

  always_comb begin
    eff = req;
    eff[S_EXT] = req[S_EXT] & ee;
    eff[S_TMR] = req[S_TMR] & ee;
    if (halted) eff = '0;
    grant = '0;
    kind  = EXC_NONE;
    for (int i = NSRC-1; i >= 0; i--) begin
      if (eff[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        kind     = exc_kind_e'(3'(i + 1));
      end
    end
    stop_go = grant[S_MC] & ~me;
    take    = (|grant) & ~stop_go;
  end

  // R3
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R4
  masked_src_chk: assert property (@(posedge clk) disable iff (rst)
    !ee |-> !(grant[S_EXT] || grant[S_TMR]));
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_HI_BASE = 32'hFFF0_0000
) (
  input  exc_kind_e       kind,
  input  logic            prefix,
  output logic [XLEN-1:0] vec_addr
);
  localparam logic [XLEN-1:0] LO_BASE = '0;

  logic [XLEN-1:0] base;

  always_comb begin
    base     = prefix ? VEC_HI_BASE : LO_BASE;
    vec_addr = base + {{(XLEN-12){1'b0}}, vec_offset(kind)};
  end
endmodule

// File: rtl/exc_save_gen.sv
module exc_save_gen
  import exc_pkg::*;
(
  input  exc_kind_e       kind,
  input  logic [XLEN-1:0] msr_cur,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] next_pc,
  input  logic [3:0]      isi_code,
  input  logic            mc_state_valid,
  output logic [XLEN-1:0] save_pc,
  output logic [XLEN-1:0] save_sr,
  output logic [XLEN-1:0] entry_msr
);
  localparam logic [XLEN-1:0] KEEP = keep_mask();

  always_comb begin
    case (kind)
      EXC_ISI, EXC_DSI, EXC_MC: save_pc = cur_pc;
      default:                  save_pc = next_pc;
    endcase

    save_sr = msr_cur & KEEP;
    if (kind == EXC_ISI) begin
      save_sr[C_HASH] = isi_code[3];
      save_sr[C_DSEG] = isi_code[2];
      save_sr[C_PROT] = isi_code[1];
      save_sr[C_STAB] = isi_code[0];
    end

    entry_msr       = msr_cur;
    entry_msr[B_IR] = 1'b0;
    entry_msr[B_DR] = 1'b0;
    entry_msr[B_PR] = 1'b0;
    entry_msr[B_EE] = 1'b0;
    entry_msr[B_RI] = (kind == EXC_MC) ? mc_state_valid : 1'b1;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] MSR_INIT    = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_sys_reset,
  input  logic        req_mcheck,
  input  logic        req_isi,
  input  logic        req_dsi,
  input  logic        req_syscall,
  input  logic        req_ext,
  input  logic        req_timer,
  input  logic        mc_state_valid,
  input  logic [3:0]  isi_code,
  input  logic [31:0] cur_pc,
  input  logic [31:0] next_pc,
  input  logic        rfi,
  input  logic        msr_load,
  input  logic [31:0] msr_wdata,
  output logic        redirect,
  output logic [31:0] redirect_pc,
  output logic [31:0] msr,
  output logic [31:0] srr0,
  output logic [31:0] srr1,
  output logic        checkstop
);
  logic [NSRC-1:0] req;
  exc_kind_e       kind;
  logic            take;
  logic            stop_go;
  logic [XLEN-1:0] vec_addr;
  logic [XLEN-1:0] save_pc;
  logic [XLEN-1:0] save_sr;
  logic [XLEN-1:0] entry_msr;

  always_comb begin
    req        = '0;
    req[S_RST] = req_sys_reset;
    req[S_MC]  = req_mcheck;
    req[S_ISI] = req_isi;
    req[S_DSI] = req_dsi;
    req[S_SC]  = req_syscall;
    req[S_EXT] = req_ext;
    req[S_TMR] = req_timer;
  end

  exc_arbiter u_arb (
    .clk(clk), .rst(rst), .req(req), .ee(msr[B_EE]), .me(msr[B_ME]),
    .halted(checkstop), .kind(kind), .take(take), .stop_go(stop_go)
  );

  exc_vector_gen #(.VEC_HI_BASE(VEC_HI_BASE)) u_vec (
    .kind(kind), .prefix(msr[B_IP]), .vec_addr(vec_addr)
  );

  exc_save_gen u_save (
    .kind(kind), .msr_cur(msr), .cur_pc(cur_pc), .next_pc(next_pc),
    .isi_code(isi_code), .mc_state_valid(mc_state_valid),
    .save_pc(save_pc), .save_sr(save_sr), .entry_msr(entry_msr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      msr         <= MSR_INIT;
      srr0        <= '0;
      srr1        <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
      checkstop   <= 1'b0;
    end else begin
      redirect <= 1'b0;
      if (!checkstop) begin
        if (stop_go) begin
          checkstop <= 1'b1;
        end else if (take) begin
          srr0        <= save_pc;
          srr1        <= save_sr;
          msr         <= entry_msr;
          redirect    <= 1'b1;
          redirect_pc <= vec_addr;
        end else if (rfi) begin
          msr         <= srr1;
          redirect    <= 1'b1;
          redirect_pc <= srr0;
        end else if (msr_load) begin
          msr <= msr_wdata;
        end
      end
    end
  end

  // R7
  entry_mode_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (redirect && !msr[B_IR] && !msr[B_DR] && !msr[B_PR] && !msr[B_EE]));

  // R2
  vec_align_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (redirect_pc[7:0] == 8'h00));

  // R9
  checkstop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> (checkstop && !redirect));

  // R9
  checkstop_entry_chk: assert property (@(posedge clk) disable iff (rst)
    stop_go |=> (checkstop && !redirect));

  // R10
  rfi_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (rfi && !take && !stop_go && !checkstop) |=>
      (redirect && msr == $past(srr1) && redirect_pc == $past(srr0)));
endmodule

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  localparam logic [31:0] HI   = 32'hFFF0_0000;
  localparam logic [31:0] INIT = 32'h0000_1040;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic r_rst = 0, r_mc = 0, r_isi = 0, r_dsi = 0, r_sc = 0, r_ext = 0, r_tmr = 0;
  logic sv = 0, rfi = 0, ld = 0;
  logic [3:0]  code = '0;
  logic [31:0] cpc = '0, npc = '0, wd = '0;
  logic        redirect, checkstop;
  logic [31:0] rpc, msr, srr0, srr1;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  exc_entry_ctrl #(.VEC_HI_BASE(HI), .MSR_INIT(INIT)) dut (
    .clk(clk), .rst(rst), .req_sys_reset(r_rst), .req_mcheck(r_mc),
    .req_isi(r_isi), .req_dsi(r_dsi), .req_syscall(r_sc), .req_ext(r_ext),
    .req_timer(r_tmr), .mc_state_valid(sv), .isi_code(code), .cur_pc(cpc),
    .next_pc(npc), .rfi(rfi), .msr_load(ld), .msr_wdata(wd),
    .redirect(redirect), .redirect_pc(rpc), .msr(msr), .srr0(srr0),
    .srr1(srr1), .checkstop(checkstop)
  );

  function automatic int mb(int b); return 31 - b; endfunction

  // reference model state
  logic [31:0] m_msr = INIT, m_s0 = '0, m_s1 = '0, m_rpc = '0;
  logic        m_red = 0, m_cs = 0;

  always @(posedge clk) begin
    int sel;
    logic [31:0] s1, nm;
    if (rst) begin
      m_msr = INIT; m_s0 = '0; m_s1 = '0; m_rpc = '0; m_red = 0; m_cs = 0;
    end else begin
      m_red = 0;
      if (!m_cs) begin
        sel = 0;
        if (r_rst) sel = 1;
        else if (r_mc) sel = 2;
        else if (r_isi) sel = 3;
        else if (r_dsi) sel = 4;
        else if (r_sc) sel = 5;
        else if (r_ext && m_msr[mb(16)]) sel = 6;
        else if (r_tmr && m_msr[mb(16)]) sel = 7;
        if (sel == 2 && !m_msr[mb(19)]) m_cs = 1;
        else if (sel != 0) begin
          s1 = '0;
          for (int b = 0; b < 32; b++)
            if (b == 0 || (b >= 5 && b <= 9) || b >= 16) s1[mb(b)] = m_msr[mb(b)];
          if (sel == 3) begin
            s1[mb(1)] = code[3]; s1[mb(3)] = code[2];
            s1[mb(4)] = code[1]; s1[mb(10)] = code[0];
          end
          m_rpc = m_msr[mb(25)] ? HI : 32'h0;
          case (sel)
            1: m_rpc += 32'h100;
            2: m_rpc += 32'h200;
            3: m_rpc += 32'h400;
            4: m_rpc += 32'h300;
            5: m_rpc += 32'hC00;
            6: m_rpc += 32'h500;
            default: m_rpc += 32'h900;
          endcase
          m_s0 = (sel == 2 || sel == 3 || sel == 4) ? cpc : npc;
          nm = m_msr;
          nm[mb(16)] = 0; nm[mb(17)] = 0; nm[mb(26)] = 0; nm[mb(27)] = 0;
          nm[mb(30)] = (sel == 2) ? sv : 1'b1;
          m_s1 = s1; m_msr = nm; m_red = 1;
        end else if (rfi) begin
          m_msr = m_s1; m_rpc = m_s0; m_red = 1;
        end else if (ld) begin
          m_msr = wd;
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7/R10/R11 msr", msr, m_msr);
      chk("R6 srr0", srr0, m_s0);
      chk("R5 srr1", srr1, m_s1);
      chk("R2 redirect", {31'b0, redirect}, {31'b0, m_red});
      chk("R2 redirect_pc", rpc, m_rpc);
      chk("R9 checkstop", {31'b0, checkstop}, {31'b0, m_cs});
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finish");
      summary();
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    {r_rst, r_mc, r_isi, r_dsi, r_sc, r_ext, r_tmr, rfi, ld} = '0;
  endtask

  task automatic load(logic [31:0] v);
    ld = 1; wd = v; step();
  endtask

  function automatic logic [31:0] req_word(int k);
    return 32'h0;
  endfunction

  logic [31:0] exp_vec [5] = '{32'hFFF0_0400, 32'hFFF0_0300, 32'hFFF0_0C00,
                               32'hFFF0_0500, 32'hFFF0_0900};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, sampled while rst is still high
    chk("R1 msr", msr, INIT);
    chk("R1 srr0", srr0, 32'h0);
    chk("R1 srr1", srr1, 32'h0);
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
    chk("R1 checkstop", {31'b0, checkstop}, 32'h0);
    rst = 0;
    step();
    // R1 first cycle after reset release
    chk("R1 msr after release", msr, INIT);
    chk("R1 redirect_pc after release", rpc, 32'h0);

    // R11 load: ME, IR, DR, PR and bit 2 set; EE and IP clear
    load(32'h2000_5030);
    chk("R11 msr load", msr, 32'h2000_5030);

    // R4 external request masked
    r_ext = 1; r_tmr = 1; step();
    chk("R4 masked redirect", {31'b0, redirect}, 32'h0);
    chk("R4 masked msr", msr, 32'h2000_5030);

    // instruction storage fault with cause flags
    cpc = 32'h0000_1000; npc = 32'h0000_1004; code = 4'b1011;
    r_isi = 1; step();
    chk("R2 isi vector", rpc, 32'h0000_0400);
    chk("R6 isi srr0", srr0, 32'h0000_1000);
    chk("R5 isi srr1", srr1, 32'h4820_5030);
    chk("R7 entry msr", msr, 32'h2000_1002);

    // R11 load loses to a return in the same cycle
    rfi = 1; ld = 1; wd = 32'h1234_5678; step();
    chk("R10 rfi msr", msr, 32'h4820_5030);
    chk("R10 rfi target", rpc, 32'h0000_1000);

    // R3 all requests at once, high base
    load(32'h0000_9040);
    {r_rst, r_mc, r_isi, r_dsi, r_sc, r_ext, r_tmr} = '1; rfi = 1; step();
    chk("R3 reset wins", rpc, 32'hFFF0_0100);
    chk("R6 reset srr0", srr0, 32'h0000_1004);

    // R8 machine check with state invalid, then valid
    load(32'h0000_9040);
    sv = 0; {r_mc, r_isi, r_dsi, r_sc, r_ext, r_tmr} = '1; step();
    chk("R3 mcheck wins", rpc, 32'hFFF0_0200);
    chk("R8 ri clear", msr, 32'h0000_1040);
    load(32'h0000_9040);
    sv = 1; r_mc = 1; step();
    chk("R8 ri set", msr, 32'h0000_1042);

    // R3 descending priority chain
    for (int k = 0; k < 5; k++) begin
      load(32'h0000_9040);
      r_isi = (k <= 0); r_dsi = (k <= 1); r_sc = (k <= 2);
      r_ext = (k <= 3); r_tmr = 1;
      step();
      chk("R3 priority chain", rpc, exp_vec[k]);
    end

    // R4 enabled external, low base
    load(32'h0000_9000);
    r_ext = 1; step();
    chk("R4 ext taken", rpc, 32'h0000_0500);

    // mixed pseudo-random phase, ME kept set
    for (int i = 0; i < 600; i++) begin
      r_rst = ($urandom % 16) == 0;
      r_mc  = ($urandom % 16) == 0;
      r_isi = ($urandom % 8) == 0;
      r_dsi = ($urandom % 8) == 0;
      r_sc  = ($urandom % 8) == 0;
      r_ext = ($urandom % 4) == 0;
      r_tmr = ($urandom % 4) == 0;
      rfi   = ($urandom % 4) == 0;
      ld    = ($urandom % 4) == 0;
      wd    = $urandom | 32'h0000_1000;
      sv    = $urandom % 2;
      code  = 4'($urandom);
      cpc   = $urandom & 32'hFFFF_FFFC;
      npc   = cpc + 4;
      step();
    end

    // R9 checkstop
    load(32'h0000_8000);
    r_mc = 1; step();
    chk("R9 checkstop set", {31'b0, checkstop}, 32'h1);
    chk("R9 no redirect", {31'b0, redirect}, 32'h0);
    r_rst = 1; r_ext = 1; rfi = 1; ld = 1; wd = 32'hFFFF_FFFF; step();
    chk("R9 frozen redirect", {31'b0, redirect}, 32'h0);
    chk("R9 frozen msr", msr, 32'h0000_8000);

    rst = 1; step(); rst = 0;
    chk("R1 msr after second reset", msr, INIT);
    chk("R1 checkstop after second reset", {31'b0, checkstop}, 32'h0);
    step();
    summary();
    $finish;
  end
endmodule